// File: doc/BRIEF.md
# Codirectional 64 kbit/s Receiver with Octet Alignment

This block takes a dual-rail, active-low 64 kbit/s codirectional line signal and turns it into eight-bit bursts inside a local 2.048 Mbit/s time-slot. A separate clock-recovery block supplies a sampling tick, `rec_tick`. Each line bit spans four unit intervals. `rec_tick` pulses twice per bit, once at unit interval 1 and once at unit interval 3. The block counts the two ticks of each bit with an internal phase bit that starts at unit interval 1 after reset. A polarity violation between consecutive bit blocks marks the last bit of an octet. Between violations the octet counter keeps running on its own.

Finished octets go into two alternating registers. One register is filled from the line while the other is played out. On every `slot_tick` (the local 2.048 MHz clock, as a one-cycle enable) the block checks the selected envelope. At the first tick of an envelope it chooses an octet and then shifts it out, first-received bit first. When the local side reads more slowly than the line delivers, the older unread octet is dropped and `delete_flag` is raised. When the local side reads faster, the last octet is played again and `repeat_flag` is raised. If violations go missing, a counter raises `octet_alarm` and can blank the affected octets. `force_ones` blanks the output unconditionally.

A violation that arrives at an unexpected bit position ends the octet early and moves the alignment to that position. It is not counted as a missed violation.

Top module: `codir_octet_rx`

## Requirements
- R1: A unit sample has positive polarity when `rail_p_n` is low and negative polarity when `rail_m_n` is low. When neither rail is low, the sample keeps the previous polarity. A decoded bit is 1 when the unit-1 and unit-3 samples of a bit differ and 0 when they match.
- R2: A bit whose unit-1 polarity equals the unit-1 polarity of the previous bit is a violation and ends the octet. Octets are played out first-received bit first, and the first received bit appears as the most significant bit of the byte.
- R3: Every octet completed since the last slot is played out once in the next slot. `repeat_flag` is 0 for such a slot, and `delete_flag` is 0 when only one octet completed in between.
- R4: When `env_pick_a` is 1, `env_a` frames the slot; when it is 0, `env_b` frames the slot. The unselected envelope has no effect. `pcm_out` is 1 outside a slot and after the eighth bit of a slot.
- R5: A slot that starts with no new octet replays the last octet played and sets `repeat_flag`. The flag holds until the next slot start.
- R6: When an octet completes while the previous one is still unread, the previous one is discarded and `delete_flag` is set. The flag holds until the next octet completes.
- R7: When the expected violation is missing and `guard_n` is 1, the octet counter freewheels and the octet data is played out unchanged.
- R8: When the expected violation is missing and `guard_n` is 0, that octet plays out as all ones.
- R9: `octet_alarm` goes high when MISS_LIMIT (8) consecutive octets end without their violation. It stays low after 7 such octets.
- R10: `octet_alarm` clears on the first violation received at the expected position.
- R11: `force_ones` high drives `pcm_out` to 1 for every bit of a slot. The stored octet is not changed.
- R12: After reset, `pcm_out` is 1 and `repeat_flag`, `delete_flag` and `octet_alarm` are 0.
- R13: `pcm_out` changes only on cycles with `slot_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rail_p_n | input | 1 | Positive line rail, active low |
| rail_m_n | input | 1 | Negative line rail, active low |
| rec_tick | input | 1 | Recovered sample enable, unit intervals 1 and 3 |
| slot_tick | input | 1 | Local 2.048 MHz bit enable |
| env_a | input | 1 | Time-slot envelope A |
| env_b | input | 1 | Time-slot envelope B |
| env_pick_a | input | 1 | 1 selects envelope A, 0 selects envelope B |
| guard_n | input | 1 | Active low: blank octets whose violation is missing |
| force_ones | input | 1 | Forces the serial output to all ones |
| pcm_out | output | 1 | Serial time-slot data |
| repeat_flag | output | 1 | Current slot replays an old octet |
| delete_flag | output | 1 | Last completed octet displaced an unread one |
| octet_alarm | output | 1 | Consecutive violations missing |

## Verification
The hardest state to reach from the ports is the alarm threshold. It needs eight octets in a row whose closing violation is missing, while the freewheeling alignment stays exactly on the line's octet grid, so that the next genuine violation falls at the expected position and clears the alarm. The bench generates the line signal from its own block-polarity model. It simply leaves out the violation for chosen octets, checks the alarm after the seventh and eighth missing octets, and then sends a normally closed octet. Slot deletion and the ignoring of the unselected envelope are reached by sending octets without reading and by pulsing only the wrong envelope.

// File: rtl/codir_octet_rx.sv
module codir_octet_rx #(
  parameter int OCT_W      = 8,
  parameter int MISS_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rail_p_n,
  input  logic rail_m_n,
  input  logic rec_tick,
  input  logic slot_tick,
  input  logic env_a,
  input  logic env_b,
  input  logic env_pick_a,
  input  logic guard_n,
  input  logic force_ones,
  output logic pcm_out,
  output logic repeat_flag,
  output logic delete_flag,
  output logic octet_alarm
);
  localparam int CW = $clog2(OCT_W);
  localparam int BW = $clog2(OCT_W + 1);
  localparam int MW = $clog2(MISS_LIMIT + 1);

  logic             phase, s1, last_pol, have_prev, prev_blk;
  logic [CW-1:0]    pos_cnt;
  logic [OCT_W-1:0] shf;
  logic [MW-1:0]    miss_cnt;
  logic [OCT_W-1:0] mem [2];
  logic [1:0]       blk, fresh;
  logic             wsel, rsel, env_q;
  logic [BW-1:0]    bcnt;

  logic pol_now, bit_now, viol, at_last, oct_end, missed, env_sel, start, newest, pick;
  logic [OCT_W-1:0] new_oct;
  logic [BW-1:0]    idx;
  logic [CW-1:0]    bit_sel;

  assign pol_now = !rail_p_n ? 1'b1 : (!rail_m_n ? 1'b0 : last_pol);
  assign bit_now = s1 ^ pol_now;
  assign viol    = have_prev && (s1 == prev_blk);
  assign at_last = pos_cnt == CW'(OCT_W - 1);
  assign oct_end = rec_tick && phase && (viol || at_last);
  assign missed  = oct_end && !viol;
  assign new_oct = {shf[OCT_W-2:0], bit_now};

  assign env_sel = env_pick_a ? env_a : env_b;
  assign start   = slot_tick && env_sel && !env_q;
  assign newest  = ~wsel;
  assign pick    = (start && fresh[newest]) ? newest : rsel;
  assign idx     = start ? '0 : bcnt;
  assign bit_sel = CW'(OCT_W - 1) - idx[CW-1:0];

  assign octet_alarm = miss_cnt == MW'(MISS_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0; s1 <= 1'b0; last_pol <= 1'b0;
      have_prev <= 1'b0; prev_blk <= 1'b0;
      pos_cnt <= '0; shf <= '0; miss_cnt <= '0;
    end else if (rec_tick) begin
      last_pol <= pol_now;
      phase    <= ~phase;
      if (!phase) s1 <= pol_now;
      else begin
        have_prev <= 1'b1;
        prev_blk  <= s1;
        shf       <= new_oct;
        pos_cnt   <= oct_end ? '0 : pos_cnt + 1'b1;
        if (oct_end && viol && at_last) miss_cnt <= '0;
        else if (missed && !octet_alarm) miss_cnt <= miss_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) mem[i] <= '1;
      blk <= '0; fresh <= '0; wsel <= 1'b0; rsel <= 1'b0;
      repeat_flag <= 1'b0; delete_flag <= 1'b0;
    end else begin
      if (start) begin
        rsel        <= pick;
        repeat_flag <= !fresh[newest];
        fresh[newest] <= 1'b0;
      end
      if (oct_end) begin
        mem[wsel]   <= new_oct;
        blk[wsel]   <= missed && !guard_n;
        fresh[wsel] <= 1'b1;
        fresh[~wsel] <= 1'b0;
        delete_flag <= fresh[~wsel];
        wsel        <= ~wsel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      env_q <= 1'b0; bcnt <= '0; pcm_out <= 1'b1;
    end else if (slot_tick) begin
      env_q <= env_sel;
      if (env_sel) begin
        pcm_out <= (force_ones || blk[pick] || idx >= BW'(OCT_W)) ? 1'b1 : mem[pick][bit_sel];
        bcnt    <= (idx >= BW'(OCT_W)) ? idx : idx + 1'b1;
      end else begin
        pcm_out <= 1'b1;
        bcnt    <= '0;
      end
    end
  end
endmodule

// File: rtl/codir_octet_rx_chk.sv
module codir_octet_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rec_tick,
  input logic slot_tick,
  input logic env_a,
  input logic env_b,
  input logic env_pick_a,
  input logic force_ones,
  input logic pcm_out,
  input logic repeat_flag,
  input logic delete_flag,
  input logic octet_alarm
);
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick && !(env_pick_a ? env_a : env_b) |=> pcm_out);

  a_r11_force_ones: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick && force_ones |=> pcm_out);

  a_r13_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(pcm_out));

  a_r9_alarm_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_tick |=> $stable(octet_alarm));

  a_r6_del_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_tick |=> $stable(delete_flag));

  a_r5_rep_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(repeat_flag));
endmodule

bind codir_octet_rx codir_octet_rx_chk u_chk (.*);

// File: tb/tb_codir_octet_rx.sv
module tb_codir_octet_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rail_p_n = 1'b1, rail_m_n = 1'b1, rec_tick = 1'b0, slot_tick = 1'b0;
  logic env_a = 1'b0, env_b = 1'b0, env_pick_a = 1'b1, guard_n = 1'b1, force_ones = 1'b0;
  logic pcm_out, repeat_flag, delete_flag, octet_alarm;

  int total = 0, bad = 0;
  logic done = 1'b0;
  logic last_blk = 1'b0;
  logic [7:0] got;

  always #4 clk = ~clk;

  codir_octet_rx dut (.*);

  // {env_pick_a, sent octet, expected octet}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 8'hA5, 8'hA5}, {1'b0, 8'h00, 8'h00}, {1'b1, 8'hFF, 8'hFF},
    {1'b0, 8'h3C, 8'h3C}, {1'b1, 8'h81, 8'h81}, {1'b0, 8'h7E, 8'h7E}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_pol(input logic p);
    rail_p_n = !p;
    rail_m_n = p;
  endtask

  task automatic rec_pulse();
    @(negedge clk) rec_tick = 1'b1;
    @(negedge clk) rec_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input logic v);
    logic blkp;
    blkp = v ? last_blk : ~last_blk;
    last_blk = blkp;
    @(negedge clk) drive_pol(blkp);
    rec_pulse();
    drive_pol(b ? ~blkp : blkp);
    rec_pulse();
  endtask

  task automatic send_oct(input logic [7:0] d, input logic close);
    for (int i = 7; i >= 0; i--) send_bit(d[i], close && (i == 0));
  endtask

  task automatic tick();
    @(negedge clk) slot_tick = 1'b1;
    @(negedge clk) slot_tick = 1'b0;
  endtask

  task automatic run_slot(input logic pick_a, input logic drive_a, output logic [7:0] d);
    @(negedge clk) begin env_pick_a = pick_a; env_a = 1'b0; env_b = 1'b0; end
    tick();
    if (drive_a) env_a = 1'b1; else env_b = 1'b1;
    for (int k = 0; k < 8; k++) begin
      tick();
      d[7-k] = pcm_out;
    end
    env_a = 1'b0; env_b = 1'b0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R12 pcm_out", pcm_out, 1);
    chk("R12 repeat_flag", repeat_flag, 0);
    chk("R12 delete_flag", delete_flag, 0);
    chk("R12 octet_alarm", octet_alarm, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int n = 0; n < 6; n++) begin
      send_oct(VEC[n][15:8], 1'b1);
      chk("R6 no delete", delete_flag, 0);
      run_slot(VEC[n][16], VEC[n][16], got);
      chk("R1 R2 R3 data", got, VEC[n][7:0]);
      chk("R3 repeat_flag", repeat_flag, 0);
      chk("R4 idle high", pcm_out, 1);
    end

    run_slot(1'b1, 1'b1, got);
    chk("R5 replay data", got, 8'h7E);
    chk("R5 repeat_flag", repeat_flag, 1);
    send_oct(8'h5A, 1'b1);
    run_slot(1'b1, 1'b1, got);
    chk("R5 fresh data", got, 8'h5A);
    chk("R5 flag cleared", repeat_flag, 0);

    send_oct(8'h11, 1'b1);
    chk("R6 first no delete", delete_flag, 0);
    send_oct(8'hC3, 1'b1);
    chk("R6 delete_flag", delete_flag, 1);
    run_slot(1'b0, 1'b0, got);
    chk("R6 newest kept", got, 8'hC3);
    chk("R6 flag holds", delete_flag, 1);
    send_oct(8'h96, 1'b1);
    chk("R6 flag clears", delete_flag, 0);

    run_slot(1'b1, 1'b0, got);
    chk("R4 unselected env ignored", got, 8'hFF);
    run_slot(1'b1, 1'b1, got);
    chk("R4 octet not consumed", got, 8'h96);
    chk("R4 not a repeat", repeat_flag, 0);

    send_oct(8'h4D, 1'b0);
    chk("R7 alarm low", octet_alarm, 0);
    run_slot(1'b1, 1'b1, got);
    chk("R7 freewheel data", got, 8'h4D);

    guard_n = 1'b0;
    send_oct(8'h2B, 1'b0);
    guard_n = 1'b1;
    run_slot(1'b0, 1'b0, got);
    chk("R8 blanked octet", got, 8'hFF);

    for (int m = 0; m < 5; m++) send_oct(8'h6E, 1'b0);
    chk("R9 seven missing", octet_alarm, 0);
    send_oct(8'h6E, 1'b0);
    chk("R9 eight missing", octet_alarm, 1);
    send_oct(8'hD2, 1'b1);
    chk("R10 alarm cleared", octet_alarm, 0);
    run_slot(1'b1, 1'b1, got);
    chk("R10 aligned data", got, 8'hD2);

    send_oct(8'h35, 1'b1);
    force_ones = 1'b1;
    run_slot(1'b1, 1'b1, got);
    chk("R11 forced ones", got, 8'hFF);
    force_ones = 1'b0;
    run_slot(1'b1, 1'b1, got);
    chk("R11 stored intact", got, 8'h35);
    chk("R11 replay flag", repeat_flag, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule